// File: doc/BRIEF.md
# Byte-Quota Round-Robin Channel Arbiter

This block decides which of several transfer channels may drive a shared data mover. Each channel brings a request, a programmable byte quota and a "done" flag; the mover reports each beat it completes and how many bytes that beat carried. A granted channel keeps the mover until it has spent its quota, finishes, or withdraws its request. The grant then passes to the next eligible channel in circular order, starting after the channel that held it last.

Any channel can be placed under external start/pause control. Such a channel stops itself when it spends a full quota, raises its paused flag and drops out of arbitration. It rejoins only when an external restart pulse arrives for it. The mover itself, and the addresses and counts it works on, belong elsewhere.

Top module: `bw_rr_arbiter`

## Requirements
- R1: The grant vector is one-hot or all zero at every cycle; after reset the grant and all paused flags are zero.
- R2: While the granted channel keeps requesting, is not done and no beat is reported, the grant does not change.
- R3: On grant a channel's remaining count is loaded with its quota; each reported beat subtracts the beat's byte count, and the beat on which the remaining count is less than or equal to the beat size is the channel's last, so a quota q at beat size b lasts ceil(q/b) beats (one beat when q is 0).
- R4: When the granted channel drops its request or raises done, the grant leaves it at the next clock edge.
- R5: A new grant goes to the first channel, scanning in ascending index order with wraparound starting just after the last granted index, that requests, is not done and is not paused; channel 0 is first after reset.
- R6: A channel with external control enabled sets its paused flag at the clock edge that ends its last quota beat, loses the grant there, and stays paused until restarted.
- R7: A restart pulse clears a channel's paused flag at the next edge, and the channel may be granted at that same edge; a restart to a channel that is not paused changes nothing.
- R8: When nothing is granted and a channel becomes eligible, the grant appears at the next clock edge.
- R9: Beats reported while nothing is granted have no effect on grant or paused flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | NCH | Per-channel request |
| done | input | NCH | Per-channel finished flag; releases and excludes the channel |
| quota | input | NCH*QW | Per-channel byte quota, channel i at bits i*QW upward |
| beat_valid | input | 1 | The mover completed one beat for the granted channel this cycle |
| beat_bytes | input | BW | Bytes carried by the reported beat |
| ext_en | input | NCH | Per-channel external start/pause enable |
| ext_restart | input | NCH | Per-channel restart pulse |
| grant | output | NCH | One-hot grant, zero when idle |
| paused | output | NCH | Per-channel paused flag |

## Verification
The bench sweeps every quota from 0 to 12 against beat sizes 1 to 5 and counts the beats a paused-enabled channel gets; a design that compared with "less than" rather than "less or equal" would hand out one beat too many on exact multiples, and one that mishandled a zero quota would never release. It walks the rotation across a withdrawn channel and a done channel, where a design that restarted the scan from index 0 would starve higher channels. A long random run against an arithmetic model then mixes pauses, restarts arriving on the pausing edge, and beats with no grant, which expose a restart that wins over a new pause or a counter that moves while idle.

// File: rtl/bw_rr_pkg.sv
package bw_rr_pkg;
  typedef enum logic [1:0] {
    REL_NONE  = 2'd0,
    REL_DROP  = 2'd1,
    REL_DONE  = 2'd2,
    REL_QUOTA = 2'd3
  } rel_cause_e;
endpackage

// File: rtl/bw_rr_pick.sv
module bw_rr_pick #(
  parameter int NCH = 4,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] elig,
  input  logic [IW-1:0]  last_idx,
  output logic           found,
  output logic [IW-1:0]  win_idx
);
  // circular scan starting just after the last granted index
  function automatic int wrap_idx(input int base, input int step);
    return (base + step) % NCH;
  endfunction

  always_comb begin
    found   = 1'b0;
    win_idx = '0;
    for (int k = 1; k <= NCH; k++) begin
      if (!found && elig[wrap_idx(int'(last_idx), k)]) begin
        found   = 1'b1;
        win_idx = IW'(wrap_idx(int'(last_idx), k));
      end
    end
  end
endmodule

// File: rtl/bw_rr_quota.sv
module bw_rr_quota #(
  parameter int QW = 16,
  parameter int BW = 8,
  localparam int CW = ((QW > BW) ? QW : BW) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [QW-1:0] load_val,
  input  logic          beat,
  input  logic [BW-1:0] beat_bytes,
  output logic [QW-1:0] rem,
  output logic          last_beat
);
  // a beat is the last one when it reaches or passes zero
  function automatic logic ends_quota(input logic [QW-1:0] r, input logic [BW-1:0] b);
    return CW'(r) <= CW'(b);
  endfunction

  assign last_beat = beat && ends_quota(rem, beat_bytes);

  always_ff @(posedge clk) begin
    if (!rst_n)                 rem <= '0;
    else if (load)              rem <= load_val;
    else if (beat && !last_beat) rem <= rem - QW'(beat_bytes);
  end

  p_rem_shrinks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !last_beat && !load) |=> (rem < $past(rem)));
endmodule

// File: rtl/bw_rr_pause.sv
module bw_rr_pause #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] set_vec,
  input  logic [NCH-1:0] restart,
  output logic [NCH-1:0] paused_q,
  output logic [NCH-1:0] paused_d
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    // a new pause wins over a restart landing on the same edge
    assign paused_d[i] = set_vec[i] | (paused_q[i] & ~restart[i]);

    always_ff @(posedge clk) begin
      if (!rst_n) paused_q[i] <= 1'b0;
      else        paused_q[i] <= paused_d[i];
    end

    p_pause_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (paused_q[i] && !restart[i]) |=> paused_q[i]);
  end
endmodule

// File: rtl/bw_rr_arbiter.sv
module bw_rr_arbiter
  import bw_rr_pkg::*;
#(
  parameter int NCH = 4,
  parameter int QW  = 16,
  parameter int BW  = 8,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    req,
  input  logic [NCH-1:0]    done,
  input  logic [NCH*QW-1:0] quota,
  input  logic              beat_valid,
  input  logic [BW-1:0]     beat_bytes,
  input  logic [NCH-1:0]    ext_en,
  input  logic [NCH-1:0]    ext_restart,
  output logic [NCH-1:0]    grant,
  output logic [NCH-1:0]    paused
);
  logic          gvalid_q;
  logic [IW-1:0] gidx_q;
  logic [IW-1:0] last_q;

  logic [QW-1:0]  rem;
  logic           exhaust;
  logic           cur_beat;
  rel_cause_e     rel_cause;
  logic           release_now;
  logic           take;
  logic           found;
  logic [IW-1:0]  win_idx;
  logic [NCH-1:0] elig;
  logic [NCH-1:0] pause_set;
  logic [NCH-1:0] paused_d;
  logic [QW-1:0]  win_quota;

  function automatic logic [NCH-1:0] idx_onehot(input logic [IW-1:0] idx);
    logic [NCH-1:0] v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction

  assign grant    = gvalid_q ? idx_onehot(gidx_q) : '0;
  assign cur_beat = gvalid_q && beat_valid;

  always_comb begin
    rel_cause = REL_NONE;
    if (gvalid_q) begin
      if (!req[gidx_q])      rel_cause = REL_DROP;
      else if (done[gidx_q]) rel_cause = REL_DONE;
      else if (exhaust)      rel_cause = REL_QUOTA;
    end
  end

  assign release_now = (rel_cause != REL_NONE);
  assign take        = !gvalid_q || release_now;
  assign pause_set   = (exhaust && ext_en[gidx_q]) ? idx_onehot(gidx_q) : '0;
  assign elig        = req & ~done & ~paused_d;
  assign win_quota   = quota[win_idx*QW +: QW];

  bw_rr_quota #(.QW(QW), .BW(BW)) u_quota (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (take && found),
    .load_val  (win_quota),
    .beat      (cur_beat),
    .beat_bytes(beat_bytes),
    .rem       (rem),
    .last_beat (exhaust)
  );

  bw_rr_pause #(.NCH(NCH)) u_pause (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (pause_set),
    .restart (ext_restart),
    .paused_q(paused),
    .paused_d(paused_d)
  );

  bw_rr_pick #(.NCH(NCH)) u_pick (
    .elig    (elig),
    .last_idx(last_q),
    .found   (found),
    .win_idx (win_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gvalid_q <= 1'b0;
      gidx_q   <= '0;
      last_q   <= IW'(NCH - 1);
    end else if (take) begin
      gvalid_q <= found;
      if (found) begin
        gidx_q <= win_idx;
        last_q <= win_idx;
      end
    end
  end

  p_grant_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  p_hold_no_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|(grant & req & ~done) && !beat_valid) |=> (grant == $past(grant)));

  p_drop_moves_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_cause == REL_DROP) |=> (grant != $past(grant)));

  p_paused_not_granted_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & paused) == '0);

  p_quota_pauses_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|pause_set) |=> (|(paused & $past(pause_set))));

  p_idle_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!gvalid_q && |(req & ~done & ~paused & ~ext_restart)) |=> (grant != '0));
endmodule

// File: tb/sim_bw_rr_arbiter.sv
module sim_bw_rr_arbiter;
  localparam int N  = 4;
  localparam int QW = 8;
  localparam int BW = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic            rst_n;
  logic [N-1:0]    req, done, ext_en, ext_restart;
  logic [N*QW-1:0] quota;
  logic            beat_valid;
  logic [BW-1:0]   beat_bytes;
  logic [N-1:0]    grant, paused;

  bw_rr_arbiter #(.NCH(N), .QW(QW), .BW(BW)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .done(done), .quota(quota),
    .beat_valid(beat_valid), .beat_bytes(beat_bytes), .ext_en(ext_en),
    .ext_restart(ext_restart), .grant(grant), .paused(paused)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // reference state: granted index (-1 idle), last index, remaining, paused
  int     m_g, m_last, m_rem;
  bit [N-1:0] m_p;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int q_of(input int i);
    return int'(quota[i*QW +: QW]);
  endfunction

  function automatic int exp_beats(input int q, input int b);
    return (q == 0) ? 1 : (q + b - 1) / b;
  endfunction

  task automatic model_step();
    bit exh, rel;
    bit [N-1:0] np;
    int pick;
    if (!rst_n) begin
      m_g = -1; m_last = N - 1; m_rem = 0; m_p = '0;
      return;
    end
    exh = (m_g >= 0) && beat_valid && (m_rem <= int'(beat_bytes));
    rel = (m_g >= 0) && (!req[m_g] || done[m_g] || exh);
    for (int i = 0; i < N; i++)
      np[i] = (i == m_g && exh && ext_en[i]) ? 1'b1 : (ext_restart[i] ? 1'b0 : m_p[i]);
    m_p = np;
    if (m_g < 0 || rel) begin
      pick = -1;
      for (int k = 1; k <= N; k++) begin
        int c = (m_last + k) % N;
        if (pick < 0 && req[c] && !done[c] && !np[c]) pick = c;
      end
      m_g = pick;
      if (pick >= 0) begin
        m_last = pick;
        m_rem  = q_of(pick);
      end
    end else if (beat_valid) begin
      m_rem = m_rem - int'(beat_bytes);
    end
  endtask

  function automatic logic [N-1:0] m_grant();
    return (m_g < 0) ? '0 : (N'(1) << m_g);
  endfunction

  task automatic tick();
    model_step();
    @(posedge clk);
    #1;
    check(grant == m_grant(), "R5 model grant", int'(grant), int'(m_grant()));
    check(paused == m_p, "R6 model paused", int'(paused), int'(m_p));
  endtask

  task automatic set_all_quota(input int q);
    for (int i = 0; i < N; i++) quota[i*QW +: QW] = QW'(q);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int cnt, guard;
    rst_n = 0; req = '0; done = '0; ext_en = '0; ext_restart = '0;
    beat_valid = 0; beat_bytes = '0; set_all_quota(0);
    m_g = -1; m_last = N - 1; m_rem = 0; m_p = '0;
    #1;
    tick(); tick();
    check(grant == '0, "R1 reset grant", int'(grant), 0);
    check(paused == '0, "R1 reset paused", int'(paused), 0);

    // R9: beats with nothing granted
    rst_n = 1; beat_valid = 1; beat_bytes = 3;
    repeat (3) tick();
    check(grant == '0, "R9 idle beat grant", int'(grant), 0);
    check(paused == '0, "R9 idle beat paused", int'(paused), 0);

    // R3/R6/R7/R8 sweep on channel 0
    ext_en = 4'b0001;
    for (int q = 0; q <= 12; q++) begin
      for (int b = 1; b <= 5; b++) begin
        quota[0 +: QW] = QW'(q); beat_bytes = BW'(b); beat_valid = 1; req = 4'b0001;
        tick();
        check(grant == 4'b0001, "R8 grant latency", int'(grant), 1);
        cnt = 0; guard = 0;
        while (!paused[0] && guard < 40) begin
          if (grant[0]) cnt++;
          guard++;
          tick();
        end
        check(cnt == exp_beats(q, b), "R3 beats per quota", cnt, exp_beats(q, b));
        check(paused[0] && grant == '0, "R6 paused after quota", int'(paused), 1);
        req = '0; ext_restart = 4'b0001;
        tick();
        ext_restart = '0;
        check(paused == '0, "R7 restart clears", int'(paused), 0);
      end
    end

    // R2 hold without beats
    ext_en = '0; beat_valid = 0; set_all_quota(8); req = 4'b0001;
    tick();
    req = 4'b0011;
    repeat (4) tick();
    check(grant == 4'b0001, "R2 hold without beat", int'(grant), 1);

    // R4 drop and done
    req = 4'b0010;
    tick();
    check(grant == 4'b0010, "R4 drop releases", int'(grant), 2);
    req = 4'b1110; done = 4'b0010;
    tick();
    check(grant == 4'b0100, "R4 done releases", int'(grant), 4);
    done = '0;

    // R5 rotation across a withdrawn channel
    req = 4'b1011; set_all_quota(2); beat_bytes = 2; beat_valid = 1;
    tick();
    check(grant == 4'b1000, "R5 rotate a", int'(grant), 8);
    tick();
    check(grant == 4'b0001, "R5 rotate b", int'(grant), 1);
    tick();
    check(grant == 4'b0010, "R5 rotate c", int'(grant), 2);
    tick();
    check(grant == 4'b1000, "R5 rotate d", int'(grant), 8);

    // R7 restart to non-paused channels
    req = '0; beat_valid = 0;
    tick();
    ext_restart = '1;
    tick();
    ext_restart = '0;
    check(paused == '0 && grant == '0, "R7 idle restart no effect", int'(paused), 0);

    // random run against the model
    for (int t = 0; t < 4000; t++) begin
      if (t % 500 == 0) ext_en = N'($urandom);
      req         = N'($urandom) | N'($urandom);
      done        = (($urandom % 16) == 0) ? N'(1) << ($urandom % N) : '0;
      beat_valid  = ($urandom % 4) != 0;
      beat_bytes  = BW'(1 + $urandom % 3);
      ext_restart = (($urandom % 6) == 0) ? N'($urandom) : '0;
      for (int i = 0; i < N; i++) quota[i*QW +: QW] = QW'($urandom % 10);
      tick();
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule